// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between clocked on-chip logic and an external asynchronous static RAM of 256K bytes. The RAM has two chip selects of opposite polarity, an output enable and a write enable. On the fabric side, a request is taken on a valid/ready handshake. Each request carries an 18-bit byte address, a data byte and a direction flag. A read returns its byte later with a one-cycle valid strobe.

The controller turns each accepted request into a strobe sequence on the RAM pins. The sequence meets the RAM's minimum and maximum times. Every time is a parameter in nanoseconds, and it is rounded up to whole cycles of the clock-period parameter. Two speed-grade presets are built in: 55 ns and 70 ns. With the defaults (5 ns clock, 55 ns grade) the cycle counts are:

| Time | Cycles |
|---|---|
| Access | 11 |
| Output enable to data | 5 |
| Cycle | 11 |
| Write pulse | 8 |
| Address to end of write | 9 |
| Data setup | 5 |
| Output release | 4 |

The data bus is split into an output, an output-enable and an input. The pad that joins them lies outside this block.

The controller keeps three rules on the RAM bus:
- It never drives the data bus while the RAM may still be driving it.
- It keeps the output enable inactive for the whole of a write.
- It releases both selects whenever no access is in progress.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is asserted, and in the cycle after its release, the outputs rest at these values: `sram_cs_n`=1, `sram_cs`=0, `sram_oe_n`=1, `sram_we_n`=1, `sram_dq_oe`=0, `rsp_valid`=0, and `req_ready`=1.
- R2: During every cycle of a read access:
  - both selects are asserted (`sram_cs_n`=0 and `sram_cs`=1);
  - `sram_we_n` is 1 and `sram_oe_n` is 0;
  - `sram_dq_oe` is 0;
  - `sram_addr` holds the request address, even if the request inputs change meanwhile.
- R3: Read data is sampled from `sram_dq_in` at the clock edge that ends cycle K of the read pins. K is the larger of ceil(tAA/Tclk) and ceil(tOE/Tclk), which is 11 by default. `rsp_valid` is 1 for exactly one cycle, directly after that edge, with the sampled byte on `rsp_data`.
- R4: In a write:
  - `sram_we_n` is 0 for exactly W consecutive cycles. W is the largest of ceil(tWP/Tclk), ceil(tAW/Tclk) and ceil(tDW/Tclk), which is 9 by default.
  - `sram_oe_n` stays 1 throughout.
  - `sram_dq_oe` is 1 in every cycle with `sram_we_n`=0, and in one guard cycle after it.
  - Address and data stay constant while `sram_we_n` is 0.
- R5: A new request is accepted only after the current access has run its full length. A read lasts max(ceil(tRC/Tclk), K) cycles, which is 11. A write lasts max(ceil(tWC/Tclk), L+W+1) cycles, where L is the lead from R6. A request that is already waiting is accepted on the last cycle of the access, with no idle cycle, so the spacing between acceptances equals the length exactly.
- R6: `sram_dq_oe` stays 0 until `sram_oe_n` has been 1 for at least ceil(tOHZ/Tclk) full cycles (4 by default). A write delays its first `sram_we_n`=0 cycle by L = max(0, 4 − number of cycles `sram_oe_n` has already been 1).
- R7: When no access is active, these outputs rest at: `sram_cs_n`=1, `sram_cs`=0, `sram_oe_n`=1, `sram_we_n`=1, `sram_dq_oe`=0, with `req_ready`=1.
- R8: A read returns the byte most recently written to the same address, including when the read directly follows the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_data | output | 8 | Read byte |
| sram_addr | output | 18 | RAM address pins |
| sram_cs_n | output | 1 | Active-low chip select |
| sram_cs | output | 1 | Active-high chip select |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_we_n | output | 1 | Active-low write enable |
| sram_dq_out | output | 8 | Byte driven toward the RAM |
| sram_dq_oe | output | 1 | Drive enable for sram_dq_out |
| sram_dq_in | input | 8 | Byte returned by the RAM |

## Verification
The bench's RAM model returns a marker byte instead of stored data until the pins have been stable for the access time. A controller that samples one cycle early therefore reads back the marker rather than the written value.

Three access pairs are issued back to back: read after read, write after write, and read after write. The spacing between acceptances is measured exactly, so both an early acceptance and an extra idle cycle are exposed.

A write that follows a read directly, and one that follows it after a short idle gap, show whether the controller counts the output-release window. The gap case checks a partial lead of one cycle. A design that ignores the window drives the bus too early. A design that always waits the full window loses that cycle.

The bench also measures the length of the write pulse and the presence of the guard cycle. Missing data hold or a pulse one cycle short then shows up as a wrong count.

// File: rtl/asram_pkg.sv
`timescale 1ns/100ps
package asram_pkg;

   typedef struct packed {
      int unsigned rc;
      int unsigned aa;
      int unsigned oe;
      int unsigned wc;
      int unsigned wp;
      int unsigned aw;
      int unsigned dw;
      int unsigned ohz;
   } grade_ns_t;

   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } op_e;

   // Nanosecond figures for the two supported speed grades
   function automatic grade_ns_t grade_table(int unsigned grade);
      grade_ns_t t;
      if (grade == 70) begin
         t.rc = 70; t.aa = 70; t.oe = 35; t.wc = 70;
         t.wp = 50; t.aw = 60; t.dw = 30; t.ohz = 25;
      end else begin
         t.rc = 55; t.aa = 55; t.oe = 25; t.wc = 55;
         t.wp = 40; t.aw = 45; t.dw = 25; t.ohz = 20;
      end
      return t;
   endfunction

   // Round a time up to whole clock cycles, never below one
   function automatic int unsigned ns_to_cycles(int unsigned ns, int unsigned clk_ns);
      int unsigned c;
      c = (ns + clk_ns - 1) / clk_ns;
      return (c == 0) ? 1 : c;
   endfunction

   function automatic int unsigned max2(int unsigned a, int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/asram_busturn.sv
`timescale 1ns/100ps
module asram_busturn #(
   parameter int unsigned OHZ_C = 4,
   parameter int unsigned LW    = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          oe_n_pin,
   input  logic          dq_oe_pin,
   output logic [LW-1:0] lead
);

   // Full cycles the output enable has been released, saturating
   logic [LW-1:0] hz;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  hz <= LW'(OHZ_C);
      else if (!oe_n_pin)          hz <= '0;
      else if (int'(hz) < int'(OHZ_C)) hz <= hz + LW'(1);
   end

   // Extra write lead needed if a write starts next cycle
   always_comb begin
      if (!oe_n_pin)                          lead = LW'(OHZ_C);
      else if (int'(hz) + 1 >= int'(OHZ_C))   lead = '0;
      else                                    lead = LW'(int'(OHZ_C) - int'(hz) - 1);
   end

   // R6
   bus_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe_pin |-> (oe_n_pin && int'(hz) >= int'(OHZ_C)));

endmodule

// File: rtl/asram_rdcap.sv
`timescale 1ns/100ps
module asram_rdcap #(
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          capture,
   input  logic [DW-1:0] dq_in,
   output logic          rsp_valid,
   output logic [DW-1:0] rsp_data
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
      end else begin
         rsp_valid <= capture;
         if (capture) rsp_data <= dq_in;
      end
   end

   // R3
   rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/asram_seq.sv
`timescale 1ns/100ps
module asram_seq
   import asram_pkg::*;
#(
   parameter int unsigned AW     = 18,
   parameter int unsigned DW     = 8,
   parameter int unsigned CAP_C  = 11,
   parameter int unsigned RLEN_C = 11,
   parameter int unsigned WC_C   = 11,
   parameter int unsigned WEN_C  = 9,
   parameter int unsigned CW     = 5,
   parameter int unsigned LW     = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic          req_write,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   input  logic [LW-1:0] lead_in,
   output logic          req_ready,
   output logic          capture,
   output logic [AW-1:0] sram_addr,
   output logic          sram_cs_n,
   output logic          sram_cs,
   output logic          sram_oe_n,
   output logic          sram_we_n,
   output logic [DW-1:0] sram_dq_out,
   output logic          sram_dq_oe
);

   op_e           op_q, op_d;
   logic [CW-1:0] cnt_q, cnt_d, len_q, len_d, lead_q, lead_d;
   logic [CW-1:0] wr_span;
   logic          last, accept, we_win_d, dq_win_d;

   assign last      = (op_q != OP_IDLE) && (cnt_q == len_q - CW'(1));
   assign req_ready = (op_q == OP_IDLE) || last;
   assign accept    = req_valid && req_ready;
   assign capture   = (op_q == OP_READ) && (cnt_q == CW'(CAP_C - 1));
   assign wr_span   = CW'(lead_in) + CW'(WEN_C + 1);

   always_comb begin
      op_d   = op_q;
      cnt_d  = cnt_q;
      len_d  = len_q;
      lead_d = lead_q;
      if (accept) begin
         cnt_d = '0;
         if (req_write) begin
            op_d   = OP_WRITE;
            lead_d = CW'(lead_in);
            len_d  = (wr_span > CW'(WC_C)) ? wr_span : CW'(WC_C);
         end else begin
            op_d   = OP_READ;
            lead_d = '0;
            len_d  = CW'(RLEN_C);
         end
      end else if (last) begin
         op_d  = OP_IDLE;
         cnt_d = '0;
      end else if (op_q != OP_IDLE) begin
         cnt_d = cnt_q + CW'(1);
      end
   end

   // Strobe windows decoded from the next state so every pin is a flop
   assign we_win_d = (op_d == OP_WRITE) && (cnt_d >= lead_d) &&
                     (cnt_d < lead_d + CW'(WEN_C));
   assign dq_win_d = (op_d == OP_WRITE) && (cnt_d >= lead_d) &&
                     (cnt_d <= lead_d + CW'(WEN_C));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q        <= OP_IDLE;
         cnt_q       <= '0;
         len_q       <= '0;
         lead_q      <= '0;
         sram_addr   <= '0;
         sram_dq_out <= '0;
         sram_cs_n   <= 1'b1;
         sram_cs     <= 1'b0;
         sram_oe_n   <= 1'b1;
         sram_we_n   <= 1'b1;
         sram_dq_oe  <= 1'b0;
      end else begin
         op_q       <= op_d;
         cnt_q      <= cnt_d;
         len_q      <= len_d;
         lead_q     <= lead_d;
         sram_cs_n  <= (op_d == OP_IDLE);
         sram_cs    <= (op_d != OP_IDLE);
         sram_oe_n  <= (op_d != OP_READ);
         sram_we_n  <= !we_win_d;
         sram_dq_oe <= dq_win_d;
         if (accept) begin
            sram_addr   <= req_addr;
            sram_dq_out <= req_wdata;
         end
      end
   end

   // R2
   read_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_oe_n |-> (!sram_cs_n && sram_cs && sram_we_n && !sram_dq_oe));

   // R4
   write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sram_we_n && !$past(sram_we_n)) |-> ($stable(sram_addr) && $stable(sram_dq_out)));

   // R4
   guard_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sram_we_n) |-> sram_dq_oe);

   // R7
   standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sram_cs_n |-> (!sram_cs && sram_we_n && sram_oe_n && !sram_dq_oe));

endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/100ps
module asram_ctrl
   import asram_pkg::*;
#(
   parameter int unsigned CLK_NS = 5,
   parameter int unsigned GRADE  = 55,
   parameter int unsigned AW     = 18,
   parameter int unsigned DW     = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic          req_write,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   output logic          rsp_valid,
   output logic [DW-1:0] rsp_data,
   output logic [AW-1:0] sram_addr,
   output logic          sram_cs_n,
   output logic          sram_cs,
   output logic          sram_oe_n,
   output logic          sram_we_n,
   output logic [DW-1:0] sram_dq_out,
   output logic          sram_dq_oe,
   input  logic [DW-1:0] sram_dq_in
);

   localparam grade_ns_t   TNS    = grade_table(GRADE);
   localparam int unsigned RC_C   = ns_to_cycles(TNS.rc,  CLK_NS);
   localparam int unsigned AA_C   = ns_to_cycles(TNS.aa,  CLK_NS);
   localparam int unsigned OE_C   = ns_to_cycles(TNS.oe,  CLK_NS);
   localparam int unsigned WC_C   = ns_to_cycles(TNS.wc,  CLK_NS);
   localparam int unsigned WP_C   = ns_to_cycles(TNS.wp,  CLK_NS);
   localparam int unsigned AWV_C  = ns_to_cycles(TNS.aw,  CLK_NS);
   localparam int unsigned DS_C   = ns_to_cycles(TNS.dw,  CLK_NS);
   localparam int unsigned OHZ_C  = ns_to_cycles(TNS.ohz, CLK_NS);
   localparam int unsigned CAP_C  = max2(AA_C, OE_C);
   localparam int unsigned RLEN_C = max2(RC_C, CAP_C);
   localparam int unsigned WEN_C  = max2(WP_C, max2(AWV_C, DS_C));
   localparam int unsigned MAXLEN = max2(RLEN_C, max2(WC_C, OHZ_C + WEN_C + 1));
   localparam int unsigned CW     = $clog2(MAXLEN + 1);
   localparam int unsigned LW     = $clog2(OHZ_C + 2);

   // Elaboration-time parameter checks
   if (GRADE != 55 && GRADE != 70) begin : g_bad_grade
      $error("asram_ctrl: GRADE must be 55 or 70");
   end
   if (CLK_NS == 0) begin : g_bad_clk
      $error("asram_ctrl: CLK_NS must be non-zero");
   end
   if (AW < 1 || DW < 1) begin : g_bad_width
      $error("asram_ctrl: AW and DW must be non-zero");
   end

   logic [LW-1:0] lead;
   logic          capture;

   asram_busturn #(.OHZ_C(OHZ_C), .LW(LW)) u_turn (
      .clk(clk), .rst_n(rst_n), .oe_n_pin(sram_oe_n),
      .dq_oe_pin(sram_dq_oe), .lead(lead)
   );

   asram_seq #(
      .AW(AW), .DW(DW), .CAP_C(CAP_C), .RLEN_C(RLEN_C), .WC_C(WC_C),
      .WEN_C(WEN_C), .CW(CW), .LW(LW)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .lead_in(lead),
      .req_ready(req_ready), .capture(capture), .sram_addr(sram_addr),
      .sram_cs_n(sram_cs_n), .sram_cs(sram_cs), .sram_oe_n(sram_oe_n),
      .sram_we_n(sram_we_n), .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe)
   );

   asram_rdcap #(.DW(DW)) u_cap (
      .clk(clk), .rst_n(rst_n), .capture(capture), .dq_in(sram_dq_in),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data)
   );

endmodule

// File: tb/sim_asram_ctrl.sv
`timescale 1ns/100ps
module sim_asram_ctrl;

   localparam int CLK_NS = 5;
   function automatic int up(int ns);
      return (ns + CLK_NS - 1) / CLK_NS;
   endfunction
   function automatic int mx(int a, int b);
      return (a > b) ? a : b;
   endfunction
   localparam int CAP_C  = mx(up(55), up(25));
   localparam int RLEN   = mx(up(55), CAP_C);
   localparam int WC_C   = up(55);
   localparam int WEN    = mx(up(40), mx(up(45), up(25)));
   localparam int OHZ_C  = up(20);
   localparam int WLEN0  = mx(WC_C, WEN + 1);
   localparam int WLENR  = mx(WC_C, OHZ_C + WEN + 1);

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [17:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic req_ready, rsp_valid, sram_cs_n, sram_cs, sram_oe_n, sram_we_n, sram_dq_oe;
   logic [7:0]  rsp_data, sram_dq_out;
   logic [7:0]  sram_dq_in = 8'hEE;
   logic [17:0] sram_addr;

   always #2.5 clk = ~clk;

   asram_ctrl #(.CLK_NS(CLK_NS), .GRADE(55)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .sram_addr(sram_addr),
      .sram_cs_n(sram_cs_n), .sram_cs(sram_cs), .sram_oe_n(sram_oe_n),
      .sram_we_n(sram_we_n), .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe),
      .sram_dq_in(sram_dq_in)
   );

   int checks = 0, errors = 0, cyc = 0;

   task automatic check(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   always @(posedge clk) cyc <= cyc + 1;

   // RAM model and pin monitors, evaluated mid-cycle
   logic [7:0] mem [int];
   int rd_cnt = 0, we_cnt = 0, oe_hi = 1000;
   logic [17:0] last_addr = '0;
   logic dq_oe_q = 1'b0, rsp_q = 1'b0;
   int rq_cyc[$];
   logic [7:0] rq_dat[$];

   always @(negedge clk) begin
      if (!sram_cs_n && sram_cs && !sram_oe_n && sram_we_n)
         rd_cnt = (rd_cnt > 0 && sram_addr == last_addr) ? rd_cnt + 1 : 1;
      else
         rd_cnt = 0;
      last_addr = sram_addr;
      if (rd_cnt >= CAP_C)
         sram_dq_in <= mem.exists(int'(sram_addr)) ? mem[int'(sram_addr)] : 8'h00;
      else
         sram_dq_in <= 8'hEE;
      if (!sram_cs_n && sram_cs && !sram_we_n) begin
         we_cnt++;
         if (!sram_dq_oe || !sram_oe_n)
            check(1'b0, "R4", "bus undriven or oe active in write", int'(sram_dq_oe), 1);
         else
            mem[int'(sram_addr)] = sram_dq_out;
      end else if (we_cnt > 0) begin
         check(we_cnt == WEN, "R4", "write pulse cycles", we_cnt, WEN);
         check(sram_dq_oe == 1'b1, "R4", "guard cycle drive", int'(sram_dq_oe), 1);
         we_cnt = 0;
      end
      if (!sram_oe_n) oe_hi = 0;
      else if (oe_hi < 1000) oe_hi++;
      if (sram_dq_oe && !dq_oe_q)
         check(oe_hi >= OHZ_C + 1, "R6", "cycles since oe release at drive", oe_hi - 1, OHZ_C);
      dq_oe_q = sram_dq_oe;
      if (rsp_valid) begin
         rq_cyc.push_back(cyc);
         rq_dat.push_back(rsp_data);
         if (rsp_q) check(1'b0, "R3", "rsp_valid longer than one cycle", 2, 1);
      end
      rsp_q = rsp_valid;
   end

   // Present a request at a negedge; return the cycle stamp after acceptance
   task automatic issue(bit wr, logic [17:0] a, logic [7:0] d, output int acc);
      int guard = 0;
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      while (!req_ready && guard < 200) begin @(negedge clk); guard++; end
      @(posedge clk);
      @(negedge clk);
      acc = cyc;
   endtask

   task automatic expect_rsp(int acc, logic [7:0] exp, string req);
      int want = acc + CAP_C;
      while (cyc < want + 1) @(negedge clk);
      if (rq_cyc.size() == 0) check(1'b0, req, "missing read response", 0, want);
      else begin
         int c = rq_cyc.pop_front();
         logic [7:0] d = rq_dat.pop_front();
         check(c == want, req, "response cycle", c, want);
         check(d == exp, req, "read data", int'(d), int'(exp));
      end
   endtask

   task automatic measure_lead(output int j);
      j = 0;
      while (sram_we_n && j < 40) begin @(negedge clk); j++; end
   endtask

   task automatic wait_idle;
      int g = 0;
      while ((!req_ready || !sram_cs_n) && g < 100) begin @(negedge clk); g++; end
      @(negedge clk);
   endtask

   task automatic t_reset;
      repeat (3) @(negedge clk);
      check(sram_cs_n && !sram_cs && sram_oe_n && sram_we_n && !sram_dq_oe && !rsp_valid,
            "R1", "pins during reset", 0, 1);
      rst_n = 1'b1;
      @(negedge clk);
      check(sram_cs_n && !sram_cs && sram_oe_n && sram_we_n && !sram_dq_oe,
            "R1", "pins after reset", 0, 1);
      check(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);
   endtask

   task automatic t_single_write_read;
      int acc, lead, accr;
      issue(1'b1, 18'h00123, 8'h5A, acc);
      req_valid = 1'b0;
      check(req_ready == 1'b0, "R5", "ready low during write", int'(req_ready), 0);
      measure_lead(lead);
      check(lead == 0, "R6", "write lead from long idle", lead, 0);
      check(sram_oe_n == 1'b1, "R4", "oe high at write start", int'(sram_oe_n), 1);
      wait_idle();
      issue(1'b0, 18'h00123, 8'h00, accr);
      req_addr = 18'h3FFFF;
      req_valid = 1'b0;
      check(!sram_cs_n && sram_cs && !sram_oe_n && sram_we_n && !sram_dq_oe,
            "R2", "read strobes", 0, 1);
      repeat (5) @(negedge clk);
      check(sram_addr == 18'h00123, "R2", "address held mid-read", int'(sram_addr), 'h123);
      expect_rsp(accr, 8'h5A, "R8");
      wait_idle();
   endtask

   task automatic t_b2b_reads;
      int a1, a2, w;
      issue(1'b1, 18'h2AAAA, 8'hC3, w); req_valid = 1'b0; wait_idle();
      issue(1'b1, 18'h15555, 8'h3C, w); req_valid = 1'b0; wait_idle();
      issue(1'b0, 18'h2AAAA, 8'h00, a1);
      issue(1'b0, 18'h15555, 8'h00, a2);
      req_valid = 1'b0;
      check(a2 - a1 == RLEN, "R5", "read to read spacing", a2 - a1, RLEN);
      expect_rsp(a1, 8'hC3, "R3");
      expect_rsp(a2, 8'h3C, "R3");
      wait_idle();
   endtask

   task automatic t_turnaround;
      int ar, aw, ar2, lead;
      issue(1'b0, 18'h2AAAA, 8'h00, ar);
      issue(1'b1, 18'h00777, 8'h96, aw);
      check(aw - ar == RLEN, "R5", "read to write spacing", aw - ar, RLEN);
      measure_lead(lead);
      check(lead == OHZ_C, "R6", "write lead right after read", lead, OHZ_C);
      issue(1'b0, 18'h00777, 8'h00, ar2);
      req_valid = 1'b0;
      check(ar2 - aw == WLENR, "R5", "delayed write length", ar2 - aw, WLENR);
      expect_rsp(ar, 8'hC3, "R3");
      expect_rsp(ar2, 8'h96, "R8");
      wait_idle();
   endtask

   task automatic t_partial_gap;
      int ar, aw, lead, exp;
      issue(1'b0, 18'h15555, 8'h00, ar);
      req_valid = 1'b0;
      while (cyc < ar + RLEN + 2) @(negedge clk);
      issue(1'b1, 18'h01000, 8'h11, aw);
      req_valid = 1'b0;
      measure_lead(lead);
      exp = mx(0, OHZ_C - (aw - ar - RLEN));
      check(lead == exp, "R6", "partial write lead after idle gap", lead, exp);
      expect_rsp(ar, 8'h3C, "R3");
      wait_idle();
   endtask

   task automatic t_b2b_writes;
      int a1, a2, ar;
      issue(1'b1, 18'h00010, 8'hA1, a1);
      issue(1'b1, 18'h00011, 8'hB2, a2);
      req_valid = 1'b0;
      check(a2 - a1 == WLEN0, "R5", "write to write spacing", a2 - a1, WLEN0);
      wait_idle();
      issue(1'b0, 18'h00010, 8'h00, ar); req_valid = 1'b0;
      expect_rsp(ar, 8'hA1, "R8");
      wait_idle();
      issue(1'b0, 18'h00011, 8'h00, ar); req_valid = 1'b0;
      expect_rsp(ar, 8'hB2, "R8");
      wait_idle();
   endtask

   task automatic t_standby;
      repeat (3) @(negedge clk);
      check(sram_cs_n && !sram_cs && sram_oe_n && sram_we_n && !sram_dq_oe,
            "R7", "standby pins", 0, 1);
      check(req_ready == 1'b1, "R7", "ready in standby", int'(req_ready), 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      t_reset();
      t_single_write_read();
      t_b2b_reads();
      t_turnaround();
      t_partial_gap();
      t_b2b_writes();
      t_standby();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule